// File: doc/BRIEF.md
# Retunable Display Clock Divider

This block produces one peripheral clock (for a pixel or video interface) from one of four candidate source clocks. The selected source is divided by a programmable ratio from 1 to 256. Software retunes it through a single 32-bit control word. Field updates are accepted only while a change-enable flag is held. A busy flag stays up until the new setting is actually in force. A stop flag parks the output low so that the source can be swapped safely.

Within this block the source clocks are modelled as single-cycle tick enables on one fast clock. Every source edge is a one-cycle pulse on its own `src_tick_i` line. The divided output `clk_o` is a registered level that moves only on ticks of the active source. Typical use has two flows. A divider-only retune sets change-enable, writes the new ratio, polls busy, then drops change-enable. A source swap sets change-enable together with stop, writes the new source, polls busy, then clears both flags.

Top module: `pclk_divider`

## Requirements
- R1: After reset the control word reads 0, `busy_o` is 0 and `clk_o` is 0, so source 0 is selected with ratio 1.
- R2: A write updates the source field and the ratio field only if change-enable was already set before that write. Otherwise both fields keep their values. Change-enable and stop are updated by every write.
- R3: The control word reads back as follows: source in bits 31:30, change-enable in bit 29, busy in bit 28 (read-only), stop in bit 27, ratio minus one in bits 7:0. All other bits read 0.
- R4: With ratio field D, one output period spans D+1 ticks of the active source. This covers every ratio from 1 (D=0) to 256 (D=255).
- R5: Within a period the output is high for floor((D+1)/2) ticks and then low for the rest, starting with a rising edge. With ratio 1 the output stays high.
- R6: While running, a new ratio takes effect only at the end of the current output period. At that point the output rises into the first new period. Busy is set from the write until that boundary.
- R7: While stop is set, the output is low from the next cycle on. A pending ratio is applied one cycle later without waiting for a boundary.
- R8: A new source selection is not applied while stop is clear. Busy stays set and the output keeps running from the old source.
- R9: With stop set, the active source switches to the requested one on the second tick of the requested source. Busy clears at that same point.
- R10: After stop is cleared, the first tick of the active source produces a rising edge that starts a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 4 | One-cycle edge enables, one per source clock |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control word read data, including busy |
| busy_o | output | 1 | A requested ratio or source is not yet active |
| clk_o | output | 1 | Divided output clock level |

## Verification
The four sources tick with periods of 2, 3, 1 and 4 system cycles. Because of this, a ratio measured against the ticks of one source reveals whether the divider is really counting that source rather than another. The tests sample the output at every tick and cover ratios 1, 2, 3, 4, 5 and 256. This separates odd duty from even duty, checks the degenerate steady-high case, and exercises the widest counter. Retunes are issued in three situations: mid-period, while stopped, and with change-enable low. These show whether updates wait for the period boundary, bypass it when parked, or are dropped. A source request made without stop is held for many cycles, which distinguishes an unsafe immediate switch from the gated two-tick handover.

// File: rtl/pclk_div_pkg.sv
`timescale 1ns/1ps
package pclk_div_pkg;
  localparam int CTRL_W   = 32;
  localparam int SRC_LSB  = 30;
  localparam int CE_BIT   = 29;
  localparam int BUSY_BIT = 28;
  localparam int STOP_BIT = 27;
  localparam int DIV_LSB  = 0;
endpackage

// File: rtl/pclk_ctrl_reg.sv
`timescale 1ns/1ps
module pclk_ctrl_reg
  import pclk_div_pkg::*;
#(
  parameter int SRC_W = 2,
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic              ce_o,
  output logic              stop_o,
  output logic [SRC_W-1:0]  req_src_o,
  output logic [DIV_W-1:0]  req_div_o
);
  logic             ce_q, stop_q;
  logic [SRC_W-1:0] req_src_q;
  logic [DIV_W-1:0] req_div_q;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b0;
      stop_q    <= 1'b0;
      req_src_q <= '0;
      req_div_q <= '0;
    end else if (wr_en_i) begin
      ce_q   <= wr_data_i[CE_BIT];
      stop_q <= wr_data_i[STOP_BIT];
      // fields open only once change-enable is already held
      if (ce_q) begin
        req_src_q <= wr_data_i[SRC_LSB +: SRC_W];
        req_div_q <= wr_data_i[DIV_LSB +: DIV_W];
      end
    end
  end

  assign ce_o      = ce_q;
  assign stop_o    = stop_q;
  assign req_src_o = req_src_q;
  assign req_div_o = req_div_q;

  // R2
  a_r2_fields_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_q |=> ($stable(req_src_q) && $stable(req_div_q)));
endmodule

// File: rtl/pclk_src_switch.sv
`timescale 1ns/1ps
module pclk_src_switch #(
  parameter int SRC_W      = 2,
  parameter int SYNC_TICKS = 2,
  localparam int NSRC      = 1 << SRC_W,
  localparam int CNT_W     = $clog2(SYNC_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_tick_i,
  input  logic             stop_i,
  input  logic [SRC_W-1:0] req_src_i,
  output logic [SRC_W-1:0] act_src_o,
  output logic             tick_o
);
  logic [SRC_W-1:0] act_src_q, req_prev_q;
  logic [CNT_W-1:0] sw_cnt_q, base_cnt;
  logic             pend, req_changed, new_tick;

  assign pend        = req_src_i != act_src_q;
  assign req_changed = req_src_i != req_prev_q;
  assign base_cnt    = req_changed ? '0 : sw_cnt_q;
  assign new_tick    = src_tick_i[req_src_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_src_q  <= '0;
      req_prev_q <= '0;
      sw_cnt_q   <= '0;
    end else begin
      req_prev_q <= req_src_i;
      if (stop_i && pend) begin
        if (new_tick) begin
          if (base_cnt == CNT_W'(SYNC_TICKS - 1)) begin
            act_src_q <= req_src_i;
            sw_cnt_q  <= '0;
          end else begin
            sw_cnt_q <= base_cnt + 1'b1;
          end
        end else begin
          sw_cnt_q <= base_cnt;
        end
      end else begin
        sw_cnt_q <= '0;
      end
    end
  end

  assign act_src_o = act_src_q;
  assign tick_o    = src_tick_i[act_src_q];

  // R8
  a_r8_hold_without_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable(act_src_q));
  // R9
  a_r9_switch_on_new_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_tick |=> $stable(act_src_q));
  a_r9_switch_to_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && pend && new_tick) |=> (act_src_q == $past(req_src_i)) || (sw_cnt_q != '0));
endmodule

// File: rtl/pclk_div_counter.sv
`timescale 1ns/1ps
module pclk_div_counter #(
  parameter int DIV_W = 8,
  localparam int N_W  = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] req_div_i,
  output logic [DIV_W-1:0] act_div_o,
  output logic             clk_o
);
  logic [DIV_W-1:0] cnt_q, act_div_q;
  logic             clk_q, wrap;
  logic [N_W-1:0]   cnt_next_ext;

  function automatic logic [N_W-1:0] hi_len(input logic [DIV_W-1:0] d);
    logic [N_W-1:0] n;
    n = {1'b0, d} + N_W'(1);
    return (n == N_W'(1)) ? N_W'(1) : (n >> 1);
  endfunction

  assign wrap         = cnt_q == act_div_q;
  assign cnt_next_ext = {1'b0, cnt_q} + N_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_div_q <= '0;
      clk_q     <= 1'b0;
    end else if (!run_i) begin
      // parked at last position so restart opens with a rising edge
      act_div_q <= req_div_i;
      cnt_q     <= req_div_i;
      clk_q     <= 1'b0;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q     <= '0;
        act_div_q <= req_div_i;
        clk_q     <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        clk_q <= cnt_next_ext < hi_len(act_div_q);
      end
    end
  end

  assign act_div_o = act_div_q;
  assign clk_o     = clk_q;

  // R4
  a_r4_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_div_q);
  // R6
  a_r6_ratio_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !(tick_i && wrap)) |=> $stable(act_div_q));
  // R5
  a_r5_rise_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && wrap) |=> clk_q);
endmodule

// File: rtl/pclk_divider.sv
`timescale 1ns/1ps
module pclk_divider
  import pclk_div_pkg::*;
#(
  parameter int SRC_W      = 2,
  parameter int DIV_W      = 8,
  parameter int SYNC_TICKS = 2,
  localparam int NSRC      = 1 << SRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_tick_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              clk_o
);
  logic             ce, stop, act_tick;
  logic [SRC_W-1:0] req_src, act_src;
  logic [DIV_W-1:0] req_div, act_div;

  pclk_ctrl_reg #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ce_o      (ce),
    .stop_o    (stop),
    .req_src_o (req_src),
    .req_div_o (req_div)
  );

  pclk_src_switch #(.SRC_W(SRC_W), .SYNC_TICKS(SYNC_TICKS)) u_sw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_tick_i (src_tick_i),
    .stop_i     (stop),
    .req_src_i  (req_src),
    .act_src_o  (act_src),
    .tick_o     (act_tick)
  );

  pclk_div_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (act_tick),
    .run_i     (!stop),
    .req_div_i (req_div),
    .act_div_o (act_div),
    .clk_o     (clk_o)
  );

  assign busy_o = (req_src != act_src) || (req_div != act_div);

  always_comb begin
    rd_data_o                         = '0;
    rd_data_o[SRC_LSB +: SRC_W]       = req_src;
    rd_data_o[CE_BIT]                 = ce;
    rd_data_o[BUSY_BIT]               = busy_o;
    rd_data_o[STOP_BIT]               = stop;
    rd_data_o[DIV_LSB +: DIV_W]       = req_div;
  end

  // R7
  a_r7_stop_holds_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !clk_o);
  // R7
  a_r7_parked_ratio_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (act_div == $past(req_div)));
endmodule

// File: tb/tb_pclk_divider.sv
`timescale 1ns/1ps
module tb_pclk_divider;
  logic        clk, rst_ni, wr_en, busy, clk_o;
  logic [3:0]  src_tick, tick_seen;
  logic [31:0] wr_data, rd_data;
  int n_chk = 0, n_fail = 0, tcnt = 0;

  pclk_divider dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_tick_i(src_tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .busy_o(busy), .clk_o(clk_o)
  );

  initial begin clk = 0; forever #2.5 clk = ~clk; end

  // source periods 2, 3, 1, 4 system cycles
  initial begin
    src_tick = '0;
    forever begin
      @(posedge clk); #1;
      tcnt++;
      src_tick[0] = (tcnt % 2) == 0;
      src_tick[1] = (tcnt % 3) == 0;
      src_tick[2] = 1'b1;
      src_tick[3] = (tcnt % 4) == 0;
    end
  end
  always @(posedge clk) tick_seen <= src_tick;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_tick(input int s);
    do @(negedge clk); while (!tick_seen[s]);
  endtask

  task automatic wait_busy_low(input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!busy) begin ok = 1; break; end
    end
  endtask

  task automatic measure(input int s, input int n, input string req);
    bit prev, found; int errs, hl;
    hl = (n == 1) ? 1 : n / 2;
    prev = clk_o; found = 0; errs = 0;
    for (int i = 0; i < 4 * n + 8; i++) begin
      wait_tick(s);
      if (clk_o && !prev) begin found = 1; break; end
      prev = clk_o;
    end
    if (!found) errs = 1;
    else for (int k = 1; k < 2 * n; k++) begin
      wait_tick(s);
      if (clk_o != ((k % n) < hl)) errs++;
    end
    check(errs == 0, req, $sformatf("ratio %0d on source %0d mismatches", n, s), errs, 0);
  endtask

  task automatic t_reset;
    rst_ni = 0; wr_en = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(rd_data == 0, "R1", "reset word", rd_data, 0);
    check(busy == 0, "R1", "reset busy", busy, 0);
    check(clk_o == 0, "R1", "reset clk", clk_o, 0);
    rst_ni = 1;
  endtask

  task automatic t_ratio_one;
    int errs = 0;
    repeat (3) wait_tick(0);
    for (int i = 0; i < 20; i++) begin wait_tick(0); if (!clk_o) errs++; end
    check(errs == 0, "R5", "ratio 1 not steady high", errs, 0);
  endtask

  task automatic t_ce_gate;
    wr(32'h0000_0005);
    @(negedge clk);
    check(rd_data == 0, "R2", "field written with change-enable low", rd_data, 0);
    check(busy == 0, "R2", "busy after ignored write", busy, 0);
  endtask

  task automatic t_first_ratio;
    bit ok;
    wr(32'h2000_0000);
    wr(32'h2000_0003);
    wait_busy_low(200, ok);
    check(ok, "R6", "busy never cleared", busy, 0);
    check(rd_data == 32'h2000_0003, "R3", "readback layout", rd_data, 32'h2000_0003);
    measure(0, 4, "R4");
  endtask

  task automatic t_div_retune;
    bit ok;
    wr(32'h2000_0002);
    check(busy == 1, "R6", "busy after ratio write", busy, 1);
    wait_busy_low(200, ok);
    check(ok && clk_o && tick_seen[0], "R6", "ratio not applied at boundary rise",
          {busy, clk_o, tick_seen[0]}, 3'b011);
    measure(0, 3, "R5");
  endtask

  task automatic t_src_no_stop;
    wr(32'h6000_0002);
    repeat (40) @(negedge clk);
    check(busy == 1 && rd_data[31:30] == 2'd1, "R8", "source pending without stop",
          {busy, rd_data[31:30]}, 3'b101);
    measure(0, 3, "R8");
  endtask

  task automatic t_src_switch;
    int t = 0, lowerr = 0; bit b1 = 0;
    wr(32'h6800_0002);
    while (t < 2) begin
      @(negedge clk);
      if (clk_o) lowerr++;
      if (tick_seen[1]) begin t++; if (t == 1) b1 = busy; end
    end
    check(lowerr == 0, "R7", "output not low while stopped", lowerr, 0);
    check(b1 == 1 && busy == 0, "R9", "busy around second new-source tick",
          {b1, busy}, 2'b10);
  endtask

  task automatic t_stop_retune;
    wr(32'h6800_0004);
    @(negedge clk);
    check(busy == 0 && clk_o == 0, "R7", "parked ratio not applied at once",
          {busy, clk_o}, 0);
  endtask

  task automatic t_restart;
    int errs = 0;
    wr(32'h4000_0004);
    while (1) begin
      @(negedge clk);
      if (tick_seen[1]) break;
      if (clk_o) errs++;
    end
    check(errs == 0 && clk_o, "R10", "first tick after stop not a rise", {errs[3:0], clk_o}, 1);
    measure(1, 5, "R4");
  endtask

  task automatic t_max_ratio;
    bit ok;
    wr(32'h6000_0004);
    wr(32'h6000_00FF);
    wait_busy_low(2000, ok);
    check(ok, "R6", "busy stuck on ratio 256", busy, 0);
    measure(1, 256, "R4");
  endtask

  task automatic t_combined_swap;
    bit ok;
    wr(32'hE800_0001);
    check((rd_data & ~32'h1000_0000) == 32'hE800_0001, "R3", "combined readback",
          rd_data, 32'hE800_0001);
    wait_busy_low(60, ok);
    check(ok, "R9", "swap to source 3 never completed", busy, 0);
    wr(32'hC000_0001);
    measure(3, 2, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio_one();
    t_ce_gate();
    t_first_ratio();
    t_div_retune();
    t_src_no_stop();
    t_src_switch();
    t_stop_retune();
    t_restart();
    t_max_ratio();
    t_combined_swap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule